// File: doc/BRIEF.md
# Memory tag check unit

This unit decides, for each load or store presented to it, whether the access has to be tag-checked. When it does, the unit derives a 4-bit physical tag from the pointer (address bits 59:56 plus bit 55, wrapping at four bits). It compares that tag with the allocation tag held for the addressed 16-byte granule. The unit also owns a small allocation-tag store. That store has a tag-read port, which returns zero whenever tags are not accessible, and a tag-write port, which faults on a misaligned address.

A small result state machine holds the outcome of the most recent request for exactly one cycle. Its states are `ST_IDLE` (no request), `ST_SKIPPED` (the check was bypassed and reported as passing), `ST_MATCH` (the check was made and passed) and `ST_MISMATCH` (the check was made and failed). On every clock edge the machine takes one of four transitions. With no request it goes to `ST_IDLE`. A request with any bypass condition goes to `ST_SKIPPED`. A checked request to untagged memory, or one whose tags match, goes to `ST_MATCH`. A checked request to tagged memory with unequal tags goes to `ST_MISMATCH`. The machine can reach any state from any state.

Top module: `mtag_check_unit`

## Requirements
- R1: When `tbi_en` is 0, a request yields `chk_req`=0, `chk_pass`=1 and `chk_fail`=0, whatever the tags.
- R2: With `match_all_en`=1, a request whose address bits 59:55 are all zeros or all ones is bypassed (`chk_req`=0, `chk_pass`=1). Any other pattern of those bits is still checked.
- R3: A request is bypassed (`chk_req`=0, `chk_pass`=1) when `tag_access_en`=0, when `req_kind` is 2 (instruction fetch) or 3 (table walk), when `check_override`=1, or when `unchecked_insn`=1. Kinds 0 (load), 1 (store) and 4 (atomic) are checkable.
- R4: The physical tag is (address bits 59:56 + address bit 55) mod 16. It is compared with the stored tag of granule index `req_addr[7:4]`.
- R5: For a checked request with `mem_tagged`=1, the outputs are `chk_pass`=1 if the tags are equal and `chk_fail`=1 otherwise. With `mem_tagged`=0 the outputs are `chk_req`=1, `chk_pass`=1 and `chk_fail`=0.
- R6: One cycle after `tag_rd_valid`, `tag_rd_data` holds the stored tag of granule `tag_rd_addr[7:4]`. It holds 0000 instead if `tag_access_en`=0 or `tag_rd_tagged`=0.
- R7: A tag write whose `tag_wr_addr[3:0]` is nonzero raises `tag_wr_fault` one cycle later and leaves the tag store unchanged.
- R8: An aligned tag write updates the store only when `tag_access_en`=1 and `tag_wr_tagged`=1. Otherwise the store is left unchanged. In either case `tag_wr_fault` is 0 one cycle later.
- R9: `chk_req`, `chk_pass` and `chk_fail` are registered and reflect the request of the previous cycle. Without a request all three are 0, and `chk_fail` is never 1 unless `chk_req` is 1. After reset all outputs and all stored tags are 0.
- R10: When a tag write and a check or tag read address the same granule in the same cycle, the check and the read use the tag stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Check request present |
| req_addr | input | 64 | Virtual address of the access |
| req_kind | input | 3 | Access kind: 0 load, 1 store, 2 fetch, 3 walk, 4 atomic |
| tbi_en | input | 1 | Top-byte-ignore active for this address |
| match_all_en | input | 1 | Match-all tag bypass enabled |
| tag_access_en | input | 1 | Allocation tags accessible |
| check_override | input | 1 | Tag-check override flag |
| unchecked_insn | input | 1 | Instruction is marked non-checked |
| mem_tagged | input | 1 | Target of the check request is tagged memory |
| tag_wr_valid | input | 1 | Tag write request |
| tag_wr_addr | input | 64 | Tag write address |
| tag_wr_data | input | 4 | Tag to store |
| tag_wr_tagged | input | 1 | Tag write target is tagged memory |
| tag_rd_valid | input | 1 | Tag read request |
| tag_rd_addr | input | 64 | Tag read address |
| tag_rd_tagged | input | 1 | Tag read target is tagged memory |
| chk_req | output | 1 | The previous request was tag-checked |
| chk_pass | output | 1 | The previous request passed or was bypassed |
| chk_fail | output | 1 | The previous request failed its check |
| tag_rd_data | output | 4 | Result of the last tag read |
| tag_wr_fault | output | 1 | Alignment fault for the previous tag write |

## Verification
A tag write and a tag check can land in the same cycle on the same granule, and so can a tag write and a tag read. The test provokes this by writing a new tag to a granule that still holds zero. In that same cycle it presents a check whose physical tag equals the new value and a read of the same granule. The outcome is correct only if the check fails and the read returns zero, since both must see the old tag. A second check and read in the next cycle must then pass and return the new tag.

// File: rtl/mtag_pkg.sv
package mtag_pkg;

    localparam logic [2:0] KIND_IFETCH = 3'd2;
    localparam logic [2:0] KIND_WALK   = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SKIPPED  = 2'd1,
        ST_MATCH    = 2'd2,
        ST_MISMATCH = 2'd3
    } chk_state_e;

    function automatic logic [3:0] phys_tag(input logic [3:0] ltag, input logic b55);
        return ltag + {3'b000, b55};
    endfunction

endpackage

// File: rtl/mtag_gate.sv
module mtag_gate
    import mtag_pkg::*;
(
    input  logic [4:0] tag_field,
    input  logic [2:0] kind,
    input  logic       tbi_en,
    input  logic       match_all_en,
    input  logic       tag_access_en,
    input  logic       check_override,
    input  logic       unchecked_insn,
    output logic       need_check,
    output logic [3:0] ptag
);

    logic field_uniform;
    logic kind_exempt;

    always_comb begin
        field_uniform = (&tag_field) || (~|tag_field);
        kind_exempt   = (kind == KIND_IFETCH) || (kind == KIND_WALK);
        need_check    = tbi_en
                      && !(match_all_en && field_uniform)
                      && tag_access_en
                      && !kind_exempt
                      && !check_override
                      && !unchecked_insn;
        ptag          = phys_tag(tag_field[4:1], tag_field[0]);
    end

endmodule

// File: rtl/mtag_store.sv
module mtag_store #(
    parameter int IDX_W    = 4,
    parameter int GRAN_LSB = 4,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic [IDX_W-1:0]    chk_idx,
    output logic [3:0]          chk_tag,
    input  logic                rd_valid,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                rd_tagged,
    output logic [3:0]          rd_data,
    input  logic                wr_valid,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [GRAN_LSB-1:0] wr_off,
    input  logic [3:0]          wr_data,
    input  logic                wr_tagged,
    output logic                wr_fault
);

    logic [DEPTH-1:0][3:0] mem_q;
    logic                  wr_misaligned;
    logic                  wr_commit;

    always_comb begin
        wr_misaligned = wr_valid && (wr_off != '0);
        wr_commit     = wr_valid && !wr_misaligned && acc_en && wr_tagged;
        chk_tag       = mem_q[chk_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q    <= '0;
            rd_data  <= '0;
            wr_fault <= 1'b0;
        end else begin
            wr_fault <= wr_misaligned;
            if (wr_commit) begin
                mem_q[wr_idx] <= wr_data;
            end
            if (rd_valid) begin
                rd_data <= (acc_en && rd_tagged) ? mem_q[rd_idx] : 4'h0;
            end
        end
    end

    AST_MISALIGNED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_misaligned |=> (wr_fault && (mem_q == $past(mem_q)))) else $error("AST_MISALIGNED_KEEPS"); // R7

    AST_GATED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (!acc_en || !wr_tagged)) |=> (mem_q == $past(mem_q))) else $error("AST_GATED_WRITE_KEEPS"); // R8

    AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (!acc_en || !rd_tagged)) |=> (rd_data == 4'h0)) else $error("AST_READ_ZERO"); // R6

endmodule

// File: rtl/mtag_check_unit.sv
module mtag_check_unit
    import mtag_pkg::*;
#(
    parameter int GRAN_BYTES = 16,
    parameter int IDX_W      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [63:0] req_addr,
    input  logic [2:0]  req_kind,
    input  logic        tbi_en,
    input  logic        match_all_en,
    input  logic        tag_access_en,
    input  logic        check_override,
    input  logic        unchecked_insn,
    input  logic        mem_tagged,
    input  logic        tag_wr_valid,
    input  logic [63:0] tag_wr_addr,
    input  logic [3:0]  tag_wr_data,
    input  logic        tag_wr_tagged,
    input  logic        tag_rd_valid,
    input  logic [63:0] tag_rd_addr,
    input  logic        tag_rd_tagged,
    output logic        chk_req,
    output logic        chk_pass,
    output logic        chk_fail,
    output logic [3:0]  tag_rd_data,
    output logic        tag_wr_fault
);

    localparam int GRAN_LSB = $clog2(GRAN_BYTES);
    localparam int IDX_HI   = GRAN_LSB + IDX_W;

    chk_state_e  state_q, state_d;
    logic        need_check;
    logic [3:0]  ptag;
    logic [3:0]  stored_tag;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[63:60], req_addr[54:IDX_HI], req_addr[GRAN_LSB-1:0],
                                tag_rd_addr[63:IDX_HI], tag_rd_addr[GRAN_LSB-1:0],
                                tag_wr_addr[63:IDX_HI]};

    mtag_gate u_gate (
        .tag_field      (req_addr[59:55]),
        .kind           (req_kind),
        .tbi_en         (tbi_en),
        .match_all_en   (match_all_en),
        .tag_access_en  (tag_access_en),
        .check_override (check_override),
        .unchecked_insn (unchecked_insn),
        .need_check     (need_check),
        .ptag           (ptag)
    );

    mtag_store #(
        .IDX_W    (IDX_W),
        .GRAN_LSB (GRAN_LSB)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (tag_access_en),
        .chk_idx   (req_addr[IDX_HI-1:GRAN_LSB]),
        .chk_tag   (stored_tag),
        .rd_valid  (tag_rd_valid),
        .rd_idx    (tag_rd_addr[IDX_HI-1:GRAN_LSB]),
        .rd_tagged (tag_rd_tagged),
        .rd_data   (tag_rd_data),
        .wr_valid  (tag_wr_valid),
        .wr_idx    (tag_wr_addr[IDX_HI-1:GRAN_LSB]),
        .wr_off    (tag_wr_addr[GRAN_LSB-1:0]),
        .wr_data   (tag_wr_data),
        .wr_tagged (tag_wr_tagged),
        .wr_fault  (tag_wr_fault)
    );

    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (!need_check) begin
            state_d = ST_SKIPPED;
        end else if (!mem_tagged || (ptag == stored_tag)) begin
            state_d = ST_MATCH;
        end else begin
            state_d = ST_MISMATCH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        chk_req  = 1'b0;
        chk_pass = 1'b0;
        chk_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SKIPPED: begin
                chk_pass = 1'b1;
            end
            ST_MATCH: begin
                chk_req  = 1'b1;
                chk_pass = 1'b1;
            end
            ST_MISMATCH: begin
                chk_req  = 1'b1;
                chk_fail = 1'b1;
            end
            default: begin
            end
        endcase
    end

    AST_TBI_OFF_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tbi_en) |=> (chk_pass && !chk_req)) else $error("AST_TBI_OFF_SKIPS"); // R1

    AST_MATCH_ALL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && match_all_en && ((&req_addr[59:55]) || (~|req_addr[59:55]))) |=> !chk_req) else $error("AST_MATCH_ALL_SKIPS"); // R2

    AST_EXEMPT_KIND_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_kind == KIND_IFETCH) || (req_kind == KIND_WALK))) |=> (chk_pass && !chk_req)) else $error("AST_EXEMPT_KIND_SKIPS"); // R3

    AST_UNTAGGED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_tagged) |=> (chk_pass && !chk_fail)) else $error("AST_UNTAGGED_PASSES"); // R5

    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!chk_req && !chk_pass && !chk_fail)) else $error("AST_NO_REQ_QUIET"); // R9

    AST_FAIL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fail |-> (chk_req && !chk_pass)) else $error("AST_FAIL_NEEDS_REQ"); // R9

endmodule

// File: tb/mtag_check_unit_test.sv
`timescale 1ns/1ps
module mtag_check_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_kind = 3'd0;
    logic        tbi_en = 1'b1;
    logic        match_all_en = 1'b0;
    logic        tag_access_en = 1'b1;
    logic        check_override = 1'b0;
    logic        unchecked_insn = 1'b0;
    logic        mem_tagged = 1'b1;
    logic        tag_wr_valid = 1'b0;
    logic [63:0] tag_wr_addr = '0;
    logic [3:0]  tag_wr_data = '0;
    logic        tag_wr_tagged = 1'b1;
    logic        tag_rd_valid = 1'b0;
    logic [63:0] tag_rd_addr = '0;
    logic        tag_rd_tagged = 1'b1;
    logic        chk_req, chk_pass, chk_fail;
    logic [3:0]  tag_rd_data;
    logic        tag_wr_fault;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mtag_check_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .tbi_en(tbi_en), .match_all_en(match_all_en),
        .tag_access_en(tag_access_en), .check_override(check_override),
        .unchecked_insn(unchecked_insn), .mem_tagged(mem_tagged),
        .tag_wr_valid(tag_wr_valid), .tag_wr_addr(tag_wr_addr), .tag_wr_data(tag_wr_data),
        .tag_wr_tagged(tag_wr_tagged), .tag_rd_valid(tag_rd_valid), .tag_rd_addr(tag_rd_addr),
        .tag_rd_tagged(tag_rd_tagged), .chk_req(chk_req), .chk_pass(chk_pass),
        .chk_fail(chk_fail), .tag_rd_data(tag_rd_data), .tag_wr_fault(tag_wr_fault)
    );

    function automatic logic [63:0] mk_addr(input logic [3:0] t, input logic b55,
                                            input logic [3:0] idx, input logic [3:0] off);
        logic [63:0] a;
        a = '0;
        a[59:56] = t;
        a[55] = b55;
        a[7:4] = idx;
        a[3:0] = off;
        return a;
    endfunction

    task automatic check_val(input string name, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", name, act, exp);
        end
    endtask

    task automatic restore_flags();
        req_kind = 3'd0; tbi_en = 1'b1; match_all_en = 1'b0; tag_access_en = 1'b1;
        check_override = 1'b0; unchecked_insn = 1'b0; mem_tagged = 1'b1;
        tag_wr_tagged = 1'b1; tag_rd_tagged = 1'b1;
    endtask

    // expected is {req, pass, fail}
    task automatic do_check(input string name, input logic [63:0] a, input logic [2:0] exp);
        @(negedge clk);
        req_addr = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_val(name, {29'd0, chk_req, chk_pass, chk_fail}, {29'd0, exp});
    endtask

    task automatic do_write(input string name, input logic [63:0] a, input logic [3:0] d,
                            input logic exp_fault);
        @(negedge clk);
        tag_wr_addr = a;
        tag_wr_data = d;
        tag_wr_valid = 1'b1;
        @(negedge clk);
        tag_wr_valid = 1'b0;
        check_val(name, {31'd0, tag_wr_fault}, {31'd0, exp_fault});
    endtask

    task automatic do_read(input string name, input logic [63:0] a, input logic [3:0] exp);
        @(negedge clk);
        tag_rd_addr = a;
        tag_rd_valid = 1'b1;
        @(negedge clk);
        tag_rd_valid = 1'b0;
        check_val(name, {28'd0, tag_rd_data}, {28'd0, exp});
    endtask

    task automatic t_reset();
        check_val("R9 reset outputs", {27'd0, chk_req, chk_pass, chk_fail, tag_wr_fault, 1'b0}, 32'd0);
        check_val("R9 reset read data", {28'd0, tag_rd_data}, 32'd0);
        do_read("R9 reset store zero", mk_addr(4'h0, 1'b0, 4'd9, 4'd0), 4'h0);
    endtask

    task automatic t_setup();
        do_write("R8 aligned write no fault", mk_addr(4'h0, 1'b0, 4'd2, 4'd0), 4'h7, 1'b0);
        do_read("R6 read back stored", mk_addr(4'h0, 1'b0, 4'd2, 4'd0), 4'h7);
    endtask

    task automatic t_tbi_off();
        tbi_en = 1'b0;
        do_check("R1 tbi off bypass", mk_addr(4'h5, 1'b0, 4'd2, 4'd0), 3'b010);
        restore_flags();
    endtask

    task automatic t_match_all();
        match_all_en = 1'b1;
        do_check("R2 all zero field bypass", mk_addr(4'h0, 1'b0, 4'd2, 4'd0), 3'b010);
        do_check("R2 all one field bypass", mk_addr(4'hF, 1'b1, 4'd2, 4'd0), 3'b010);
        do_check("R2 mixed field still checked", mk_addr(4'h0, 1'b1, 4'd2, 4'd0), 3'b101);
        restore_flags();
    endtask

    task automatic t_bypass();
        logic [63:0] a;
        a = mk_addr(4'h3, 1'b0, 4'd2, 4'd0);
        tag_access_en = 1'b0;
        do_check("R3 tag access off", a, 3'b010);
        restore_flags();
        req_kind = 3'd2;
        do_check("R3 fetch kind", a, 3'b010);
        req_kind = 3'd3;
        do_check("R3 walk kind", a, 3'b010);
        restore_flags();
        check_override = 1'b1;
        do_check("R3 override", a, 3'b010);
        restore_flags();
        unchecked_insn = 1'b1;
        do_check("R3 unchecked insn", a, 3'b010);
        restore_flags();
        req_kind = 3'd1;
        do_check("R3 store kind checked", a, 3'b101);
        restore_flags();
    endtask

    task automatic t_ptag();
        do_write("R8 write zero tag", mk_addr(4'h0, 1'b0, 4'd3, 4'd0), 4'h0, 1'b0);
        do_write("R8 write tag 9", mk_addr(4'h0, 1'b0, 4'd3, 4'd0), 4'h9, 1'b0);
        do_write("R8 write tag 0 again", mk_addr(4'h0, 1'b0, 4'd3, 4'd0), 4'h0, 1'b0);
        do_check("R4 wrap F plus 1 matches 0", mk_addr(4'hF, 1'b0, 4'd3, 4'd0) | (64'd1 << 55), 3'b110);
        do_check("R4 6 plus 1 matches 7", mk_addr(4'h6, 1'b1, 4'd2, 4'd0), 3'b110);
        do_check("R4 7 plus 1 misses 7", mk_addr(4'h7, 1'b1, 4'd2, 4'd0), 3'b101);
        do_check("R4 7 plus 0 matches 7", mk_addr(4'h7, 1'b0, 4'd2, 4'hC), 3'b110);
        do_check("R4 granule index selects entry", mk_addr(4'h7, 1'b0, 4'd3, 4'd0), 3'b101);
    endtask

    task automatic t_untagged();
        mem_tagged = 1'b0;
        do_check("R5 untagged mismatch passes", mk_addr(4'h4, 1'b0, 4'd2, 4'd0), 3'b110);
        restore_flags();
        req_kind = 3'd4;
        do_check("R5 atomic mismatch fails", mk_addr(4'h4, 1'b0, 4'd2, 4'd0), 3'b101);
        restore_flags();
    endtask

    task automatic t_idle();
        do_check("R9 fail before idle", mk_addr(4'h1, 1'b0, 4'd2, 4'd0), 3'b101);
        @(negedge clk);
        check_val("R9 quiet without request", {29'd0, chk_req, chk_pass, chk_fail}, 32'd0);
    endtask

    task automatic t_read();
        tag_access_en = 1'b0;
        do_read("R6 read with access off", mk_addr(4'h0, 1'b0, 4'd2, 4'd0), 4'h0);
        restore_flags();
        tag_rd_tagged = 1'b0;
        do_read("R6 read untagged", mk_addr(4'h0, 1'b0, 4'd2, 4'd0), 4'h0);
        restore_flags();
        do_read("R6 read tagged", mk_addr(4'h0, 1'b0, 4'd2, 4'd8), 4'h7);
    endtask

    task automatic t_misaligned();
        do_write("R7 misaligned faults", mk_addr(4'h0, 1'b0, 4'd2, 4'd4), 4'h9, 1'b1);
        do_read("R7 misaligned left store", mk_addr(4'h0, 1'b0, 4'd2, 4'd0), 4'h7);
        do_write("R7 offset one faults", mk_addr(4'h0, 1'b0, 4'd6, 4'd1), 4'h5, 1'b1);
        do_read("R7 offset one left store", mk_addr(4'h0, 1'b0, 4'd6, 4'd0), 4'h0);
    endtask

    task automatic t_gated_write();
        tag_access_en = 1'b0;
        do_write("R8 write access off", mk_addr(4'h0, 1'b0, 4'd4, 4'd0), 4'hA, 1'b0);
        restore_flags();
        do_read("R8 access off no update", mk_addr(4'h0, 1'b0, 4'd4, 4'd0), 4'h0);
        tag_wr_tagged = 1'b0;
        do_write("R8 write untagged", mk_addr(4'h0, 1'b0, 4'd4, 4'd0), 4'hA, 1'b0);
        restore_flags();
        do_read("R8 untagged no update", mk_addr(4'h0, 1'b0, 4'd4, 4'd0), 4'h0);
        do_write("R8 enabled write", mk_addr(4'h0, 1'b0, 4'd4, 4'd0), 4'hA, 1'b0);
        do_read("R8 enabled updates", mk_addr(4'h0, 1'b0, 4'd4, 4'd0), 4'hA);
    endtask

    task automatic t_collide();
        @(negedge clk);
        tag_wr_addr = mk_addr(4'h0, 1'b0, 4'd5, 4'd0);
        tag_wr_data = 4'h3;
        tag_wr_valid = 1'b1;
        req_addr = mk_addr(4'h3, 1'b0, 4'd5, 4'd0);
        req_valid = 1'b1;
        tag_rd_addr = mk_addr(4'h0, 1'b0, 4'd5, 4'd0);
        tag_rd_valid = 1'b1;
        @(negedge clk);
        tag_wr_valid = 1'b0;
        check_val("R10 check sees old tag", {29'd0, chk_req, chk_pass, chk_fail}, 32'b101);
        check_val("R10 read sees old tag", {28'd0, tag_rd_data}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        tag_rd_valid = 1'b0;
        check_val("R10 next check sees new tag", {29'd0, chk_req, chk_pass, chk_fail}, 32'b110);
        check_val("R10 next read sees new tag", {28'd0, tag_rd_data}, 32'h3);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !finished) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_tbi_off();
        t_match_all();
        t_bypass();
        t_ptag();
        t_untagged();
        t_idle();
        t_read();
        t_misaligned();
        t_gated_write();
        t_collide();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule